// File: doc/BRIEF.md
# I2C Message List Sequencer

The sequencer is a transfer engine that sits above a byte-level I2C master core. Software, or a neighbouring block, first fills a small descriptor table. Each entry holds a 7-bit target address, a flag field and a 16-bit byte count. A single `go` pulse then starts the engine, which works through the first `msg_count` entries. It reacts to the status codes that the core reports on each event. In response it issues one-cycle command pulses: set start, clear start, stop, acknowledge enable, acknowledge disable, event clear, core disable and core enable. Data bytes arrive through a byte-stream input and leave through a byte-stream output. Each streamed byte is tagged with the descriptor it belongs to.

A descriptor that carries the no-start flag and has the same direction as the entry before it is fused with that entry into one continuous byte run. The engine sends no repeated start between fused entries. It moves from one entry's bytes to the next entry's bytes without any bus event, and it skips zero-length entries.

When the list is finished, or the transfer fails, the engine raises `done` for exactly one cycle together with a result code. A cycle-count timeout guards every transfer. When it expires, the engine turns the core off and then on again and reports the timeout code.

Top module: `i2c_msg_seq`

## Requirements
- R1: After reset, `busy` and `done` are low and `core_cmd`, `core_wr`, `tx_take` and `rx_put` are all zero.
- R2: A `go` pulse with `msg_count` = 0 gives `done` in the next cycle with result 0 (success). No command is issued.
- R3: Flag bit 0 means read and flag bit 1 means no-start. The request is rejected, with `done` and result 2 (invalid) in the next cycle and no command, in either of two cases. The first case is that entry 0 has any bit other than bit 0 set. The second case is that any later entry below `msg_count` has a bit other than bits 0 and 1 set. Entries at or above `msg_count` are not checked.
- R4: A valid `go` raises `busy` and issues a set-start command, which is `core_cmd` bit 0. A `go` pulse while `busy` is high has no effect.
- R5: On status 0x08 or 0x10, the engine writes the address byte of the run head, {addr, read flag}. In the same cycle it issues acknowledge enable, clear start and event clear (`core_cmd` bits 3, 1 and 5).
- R6: A run covers its head entry plus each following entry that has the no-start flag and the same read flag. It stops at the first entry that does not match. Inside a run, successive bytes move on to the next non-empty entry, and `byte_idx` reports that entry. No command marks the boundary.
- R7: On status 0x18 or 0x28 with bytes left in the run, the engine takes one byte from `tx_data` (`tx_take` with `core_wr`) and issues acknowledge enable and event clear. On status 0x30 with bytes left, it issues stop (bit 2) and event clear, and it ends with result 1 (I/O error).
- R8: On status 0x40, the engine issues acknowledge enable if more than one byte is left, otherwise acknowledge disable (bit 4), each with event clear. On status 0x50 or 0x58, it pushes `core_rdata` out through `rx_put`. If more than one byte then remains it issues acknowledge enable, and if exactly one remains it issues acknowledge disable.
- R9: When a run runs out of bytes, the engine looks at the next entry. If there is none, it issues stop and event clear and ends with success. If the next entry lacks the no-start flag, it issues set start and event clear and begins a new run. If the next entry has the no-start flag, it issues stop and event clear and ends with result 2.
- R10: On status 0x00, 0x20 or 0x48, the engine issues stop, acknowledge enable and event clear, and ends with result 1. Status 0xF8 is ignored. Any other unlisted status ends the transfer with result 1 and issues no command.
- R11: If the transfer is still busy `tmo_cycles` cycles after `go`, the engine issues core disable (bit 6). In the following cycle it issues core enable (bit 7) together with `done` and result 3 (timeout).
- R12: `done` lasts one cycle, and `busy` is low while `done` is high. `result` holds its value until the next transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_sel | input | 3 | Descriptor slot to write |
| tbl_addr | input | 7 | Target address for the slot |
| tbl_flags | input | 4 | Flags: bit 0 read, bit 1 no-start, other bits unsupported |
| tbl_len | input | 16 | Byte count for the slot |
| go | input | 1 | Start pulse |
| msg_count | input | 4 | Number of descriptors in the list (0 to 8) |
| tmo_cycles | input | 24 | Timeout in clock cycles |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 I/O error, 2 invalid, 3 timeout |
| core_evt | input | 1 | Core event pending; `core_status` is valid |
| core_status | input | 8 | Core status code |
| core_rdata | input | 8 | Byte received by the core |
| core_cmd | output | 8 | Command pulses: 0 set start, 1 clear start, 2 stop, 3 ack enable, 4 ack disable, 5 event clear, 6 core off, 7 core on |
| core_wr | output | 1 | Write `core_wdata` into the core |
| core_wdata | output | 8 | Byte for the core (address or data) |
| tx_data | input | 8 | Next outgoing byte |
| tx_take | output | 1 | Outgoing byte consumed |
| rx_put | output | 1 | Incoming byte valid on `rx_data` |
| rx_data | output | 8 | Incoming byte |
| byte_idx | output | 3 | Descriptor index of the byte that was taken or put |

## Verification
The hardest situation to reach from the ports is a fused run whose byte pointer has to cross a zero-length entry. Right after that run, the engine must choose between a repeated start and a rejection, depending on the flags of the entry that follows. The bench builds a five-entry list to get there. The list holds a write head, an empty no-start write, a two-byte no-start write, a read head, and a no-start read. The bench then plays the core's status codes one event at a time, and the scoreboard expects the byte indices 0, 2, 2, 3 and 4. A separate list places a no-start read directly after a write to force the rejection branch in the middle of a transfer.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   typedef enum logic [1:0] {
      RES_OK    = 2'd0,
      RES_IOERR = 2'd1,
      RES_INVAL = 2'd2,
      RES_TMO   = 2'd3
   } res_e;

   // flag bit positions inside a descriptor
   localparam int FLG_READ    = 0;
   localparam int FLG_NOSTART = 1;

   // command pulse masks
   localparam logic [7:0] CMD_START_SET = 8'h01;
   localparam logic [7:0] CMD_START_CLR = 8'h02;
   localparam logic [7:0] CMD_STOP      = 8'h04;
   localparam logic [7:0] CMD_ACK_EN    = 8'h08;
   localparam logic [7:0] CMD_ACK_DIS   = 8'h10;
   localparam logic [7:0] CMD_EVT_CLR   = 8'h20;
   localparam logic [7:0] CMD_CORE_OFF  = 8'h40;
   localparam logic [7:0] CMD_CORE_ON   = 8'h80;

   // core status codes
   localparam logic [7:0] ST_BUS_ERR  = 8'h00;
   localparam logic [7:0] ST_START    = 8'h08;
   localparam logic [7:0] ST_RESTART  = 8'h10;
   localparam logic [7:0] ST_AW_ACK   = 8'h18;
   localparam logic [7:0] ST_AW_NACK  = 8'h20;
   localparam logic [7:0] ST_DW_ACK   = 8'h28;
   localparam logic [7:0] ST_DW_NACK  = 8'h30;
   localparam logic [7:0] ST_AR_ACK   = 8'h40;
   localparam logic [7:0] ST_AR_NACK  = 8'h48;
   localparam logic [7:0] ST_DR_ACK   = 8'h50;
   localparam logic [7:0] ST_DR_NACK  = 8'h58;
   localparam logic [7:0] ST_NOTHING  = 8'hF8;

endpackage

// File: rtl/i2cseq_desc_table.sv
module i2cseq_desc_table #(
   parameter int DEPTH  = 8,
   parameter int LEN_W  = 16,
   parameter int FLAG_W = 4,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 sel,
   input  logic [6:0]                       wr_addr,
   input  logic [FLAG_W-1:0]                wr_flags,
   input  logic [LEN_W-1:0]                 wr_len,
   input  logic [IDX_W:0]                   count,
   output logic [DEPTH-1:0][6:0]            addr_v,
   output logic [DEPTH-1:0][LEN_W-1:0]      len_v,
   output logic [DEPTH-1:0]                 rd_v,
   output logic [DEPTH-1:0]                 ns_v,
   output logic                             req_bad
);
   import i2cseq_pkg::*;

   localparam logic [FLAG_W-1:0] OK_HEAD = FLAG_W'(1) << FLG_READ;
   localparam logic [FLAG_W-1:0] OK_REST = OK_HEAD | (FLAG_W'(1) << FLG_NOSTART);

   logic [DEPTH-1:0][FLAG_W-1:0] flg_q;
   logic [DEPTH-1:0]             bad_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_v <= '0;
         len_v  <= '0;
         flg_q  <= '0;
      end else if (we) begin
         addr_v[sel] <= wr_addr;
         len_v[sel]  <= wr_len;
         flg_q[sel]  <= wr_flags;
      end
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      localparam logic [FLAG_W-1:0] OKM = (k == 0) ? OK_HEAD : OK_REST;
      assign rd_v[k]  = flg_q[k][FLG_READ];
      assign ns_v[k]  = flg_q[k][FLG_NOSTART];
      assign bad_e[k] = (k < int'(count)) && ((flg_q[k] & ~OKM) != '0);
   end

   assign req_bad = (bad_e != '0) || (int'(count) > DEPTH);

endmodule

// File: rtl/i2cseq_run_calc.sv
module i2cseq_run_calc #(
   parameter int DEPTH = 8,
   parameter int LEN_W = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int RUN_W = LEN_W + IDX_W
) (
   input  logic [DEPTH-1:0][LEN_W-1:0] len_v,
   input  logic [DEPTH-1:0]            rd_v,
   input  logic [DEPTH-1:0]            ns_v,
   input  logic [IDX_W:0]              count,
   input  logic [IDX_W-1:0]            head,
   output logic [RUN_W-1:0]            run_len,
   output logic [IDX_W:0]              run_end
);
   logic [DEPTH-1:0] joins;

   for (genvar k = 0; k < DEPTH; k++) begin : g_join
      assign joins[k] = ns_v[k] && (rd_v[k] == rd_v[head]) && (k < int'(count));
   end

   always_comb begin
      logic alive;
      alive   = 1'b1;
      run_len = RUN_W'(len_v[head]);
      run_end = (IDX_W+1)'(head) + 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
         if (k > int'(head)) begin
            if (alive && joins[k]) begin
               run_len = run_len + RUN_W'(len_v[k]);
               run_end = (IDX_W+1)'(k + 1);
            end else begin
               alive = 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
   parameter int TMO_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMO_W-1:0] load_val,
   input  logic             run,
   input  logic             clear,
   output logic             expired
);
   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clear)                cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = run && (cnt_q == '0);

endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq #(
   parameter int DEPTH  = 8,
   parameter int LEN_W  = 16,
   parameter int FLAG_W = 4,
   parameter int TMO_W  = 24,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int RUN_W = LEN_W + IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_sel,
   input  logic [6:0]        tbl_addr,
   input  logic [FLAG_W-1:0] tbl_flags,
   input  logic [LEN_W-1:0]  tbl_len,
   input  logic              go,
   input  logic [IDX_W:0]    msg_count,
   input  logic [TMO_W-1:0]  tmo_cycles,
   output logic              busy,
   output logic              done,
   output logic [1:0]        result,
   input  logic              core_evt,
   input  logic [7:0]        core_status,
   input  logic [7:0]        core_rdata,
   output logic [7:0]        core_cmd,
   output logic              core_wr,
   output logic [7:0]        core_wdata,
   input  logic [7:0]        tx_data,
   output logic              tx_take,
   output logic              rx_put,
   output logic [7:0]        rx_data,
   output logic [IDX_W-1:0]  byte_idx
);
   import i2cseq_pkg::*;

   if (DEPTH < 2 || LEN_W < 1 || FLAG_W < 2 || TMO_W < 2) begin : g_bad_cfg
      $error("i2c_msg_seq: unsupported parameter set");
   end

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_OFF} st_e;

   logic [DEPTH-1:0][6:0]       tab_addr;
   logic [DEPTH-1:0][LEN_W-1:0] tab_len;
   logic [DEPTH-1:0]            rd_v, ns_v;
   logic                        req_bad, tmr_expired, tmr_load, fin;
   logic [RUN_W-1:0]            run_len;
   logic [IDX_W:0]              run_end, calc_count;
   logic [IDX_W-1:0]            calc_head;

   st_e              state_q, st_n;
   logic             busy_q, busy_n, done_q, done_n;
   res_e             res_q, res_n, fin_res;
   logic [IDX_W-1:0] head_q, head_n, cur_q, cur_n, bidx_q, bidx_n, eff_idx;
   logic [IDX_W:0]   end_q, end_n, cnt_q, cnt_n;
   logic [LEN_W-1:0] left_q, left_n, eff_left;
   logic [RUN_W-1:0] todo_q, todo_n;
   logic [7:0]       cmd_q, cmd_n, wdata_q, wdata_n, rxd_q, rxd_n;
   logic             wr_q, wr_n, take_q, take_n, put_q, put_n;
   logic             do_setup, do_next;

   assign calc_head  = (state_q == S_IDLE) ? '0 : end_q[IDX_W-1:0];
   assign calc_count = (state_q == S_IDLE) ? msg_count : cnt_q;

   i2cseq_desc_table #(.DEPTH(DEPTH), .LEN_W(LEN_W), .FLAG_W(FLAG_W)) u_tab (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .sel(tbl_sel),
      .wr_addr(tbl_addr), .wr_flags(tbl_flags), .wr_len(tbl_len),
      .count(calc_count), .addr_v(tab_addr), .len_v(tab_len),
      .rd_v(rd_v), .ns_v(ns_v), .req_bad(req_bad)
   );

   i2cseq_run_calc #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_run (
      .len_v(tab_len), .rd_v(rd_v), .ns_v(ns_v), .count(calc_count),
      .head(calc_head), .run_len(run_len), .run_end(run_end)
   );

   i2cseq_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmo_cycles),
      .run(state_q == S_RUN), .clear(fin), .expired(tmr_expired)
   );

   // first entry at or after the byte pointer that still holds bytes
   always_comb begin
      logic found;
      eff_idx  = cur_q;
      eff_left = left_q;
      found    = (left_q != '0);
      for (int k = 0; k < DEPTH; k++) begin
         if (!found && k > int'(cur_q) && tab_len[k] != '0) begin
            eff_idx  = IDX_W'(k);
            eff_left = tab_len[k];
            found    = 1'b1;
         end
      end
   end

   always_comb begin
      st_n = state_q;  busy_n = busy_q;  res_n = res_q;
      head_n = head_q; end_n = end_q;    cur_n = cur_q;
      left_n = left_q; todo_n = todo_q;  cnt_n = cnt_q;
      cmd_n = '0;  wr_n = 1'b0;  wdata_n = wdata_q;  take_n = 1'b0;
      put_n = 1'b0; rxd_n = rxd_q; bidx_n = bidx_q;  done_n = 1'b0;
      do_setup = 1'b0; do_next = 1'b0; fin = 1'b0; fin_res = RES_OK;
      tmr_load = 1'b0;
      unique case (state_q)
         S_IDLE: if (go) begin
            cnt_n = msg_count;
            if (msg_count == '0) begin
               fin = 1'b1; fin_res = RES_OK;
            end else if (req_bad) begin
               fin = 1'b1; fin_res = RES_INVAL;
            end else begin
               do_setup = 1'b1; cmd_n = CMD_START_SET;
               busy_n = 1'b1; tmr_load = 1'b1; st_n = S_RUN;
            end
         end
         S_RUN: if (tmr_expired) begin
            cmd_n = CMD_CORE_OFF; st_n = S_OFF;
         end else if (core_evt) begin
            case (core_status)
               ST_BUS_ERR, ST_AW_NACK, ST_AR_NACK: begin
                  cmd_n = CMD_STOP | CMD_ACK_EN | CMD_EVT_CLR;
                  fin = 1'b1; fin_res = RES_IOERR;
               end
               ST_START, ST_RESTART: begin
                  wr_n = 1'b1;
                  wdata_n = {tab_addr[head_q], rd_v[head_q]};
                  cmd_n = CMD_ACK_EN | CMD_START_CLR | CMD_EVT_CLR;
               end
               ST_AW_ACK, ST_DW_ACK: begin
                  if (todo_q != '0) begin
                     take_n = 1'b1; wr_n = 1'b1; wdata_n = tx_data;
                     bidx_n = eff_idx; cur_n = eff_idx;
                     left_n = eff_left - 1'b1; todo_n = todo_q - 1'b1;
                     cmd_n = CMD_ACK_EN | CMD_EVT_CLR;
                  end else do_next = 1'b1;
               end
               ST_DW_NACK: begin
                  if (todo_q == '0) do_next = 1'b1;
                  else begin
                     cmd_n = CMD_STOP | CMD_EVT_CLR;
                     fin = 1'b1; fin_res = RES_IOERR;
                  end
               end
               ST_AR_ACK:
                  cmd_n = (todo_q > RUN_W'(1)) ? (CMD_ACK_EN | CMD_EVT_CLR)
                                               : (CMD_ACK_DIS | CMD_EVT_CLR);
               ST_DR_ACK, ST_DR_NACK: begin
                  if (todo_q != '0) begin
                     put_n = 1'b1; rxd_n = core_rdata;
                     bidx_n = eff_idx; cur_n = eff_idx;
                     left_n = eff_left - 1'b1; todo_n = todo_q - 1'b1;
                     if (todo_q > RUN_W'(2))       cmd_n = CMD_ACK_EN | CMD_EVT_CLR;
                     else if (todo_q == RUN_W'(2)) cmd_n = CMD_ACK_DIS | CMD_EVT_CLR;
                     else                          do_next = 1'b1;
                  end else do_next = 1'b1;
               end
               ST_NOTHING: ;
               default: begin
                  fin = 1'b1; fin_res = RES_IOERR;
               end
            endcase
         end
         S_OFF: begin
            cmd_n = CMD_CORE_ON; fin = 1'b1; fin_res = RES_TMO;
         end
         default: st_n = S_IDLE;
      endcase

      if (do_next) begin
         if (end_q < cnt_q) begin
            if (ns_v[end_q[IDX_W-1:0]]) begin
               cmd_n = cmd_n | CMD_STOP | CMD_EVT_CLR;
               fin = 1'b1; fin_res = RES_INVAL;
            end else begin
               do_setup = 1'b1;
               cmd_n = cmd_n | CMD_START_SET | CMD_EVT_CLR;
            end
         end else begin
            cmd_n = cmd_n | CMD_STOP | CMD_EVT_CLR;
            fin = 1'b1; fin_res = RES_OK;
         end
      end
      if (do_setup) begin
         head_n = calc_head; cur_n = calc_head;
         left_n = tab_len[calc_head]; todo_n = run_len; end_n = run_end;
      end
      if (fin) begin
         done_n = 1'b1; busy_n = 1'b0; res_n = fin_res; st_n = S_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE; busy_q <= 1'b0; done_q <= 1'b0; res_q <= RES_OK;
         head_q <= '0; end_q <= '0; cur_q <= '0; left_q <= '0; todo_q <= '0;
         cnt_q <= '0; cmd_q <= '0; wr_q <= 1'b0; wdata_q <= '0;
         take_q <= 1'b0; put_q <= 1'b0; rxd_q <= '0; bidx_q <= '0;
      end else begin
         state_q <= st_n; busy_q <= busy_n; done_q <= done_n; res_q <= res_n;
         head_q <= head_n; end_q <= end_n; cur_q <= cur_n; left_q <= left_n;
         todo_q <= todo_n; cnt_q <= cnt_n; cmd_q <= cmd_n; wr_q <= wr_n;
         wdata_q <= wdata_n; take_q <= take_n; put_q <= put_n;
         rxd_q <= rxd_n; bidx_q <= bidx_n;
      end
   end

   assign busy       = busy_q;
   assign done       = done_q;
   assign result     = res_q;
   assign core_cmd   = cmd_q;
   assign core_wr    = wr_q;
   assign core_wdata = wdata_q;
   assign tx_take    = take_q;
   assign rx_put     = put_q;
   assign rx_data    = rxd_q;
   assign byte_idx   = bidx_q;

   // R12: completion is a single-cycle pulse
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R12: the engine is idle whenever it reports completion
   assert_idle_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9: start and stop are never requested together
   assert_no_start_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(core_cmd[0] && core_cmd[2]));
   // R11: core disable is followed by core enable and a timeout completion
   assert_off_then_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
      core_cmd[6] |=> (core_cmd[7] && done && result == 2'd3));
   // R2: an empty list completes at once without a command
   assert_empty_list_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && state_q == S_IDLE && go && msg_count == '0) |=>
      (done && result == 2'd0 && core_cmd == 8'h00));
   // R7: a consumed outgoing byte is always written to the core
   assert_take_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> (core_wr && !rx_put));

endmodule

// File: tb/sim_i2c_msg_seq.sv
module sim_i2c_msg_seq;
   localparam int CLK_PERIOD = 10;

   // command masks and result codes taken from the requirements
   localparam logic [7:0] C_SS = 8'h01, C_SC = 8'h02, C_SP = 8'h04, C_AE = 8'h08,
                          C_AD = 8'h10, C_EC = 8'h20, C_OFF = 8'h40, C_ON = 8'h80;

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       tbl_we = 0;  logic [2:0] tbl_sel = 0;  logic [6:0] tbl_addr = 0;
   logic [3:0] tbl_flags = 0; logic [15:0] tbl_len = 0;
   logic       go = 0;      logic [3:0] msg_count = 0; logic [23:0] tmo_cycles = 24'd1000;
   logic       busy, done;  logic [1:0] result;
   logic       core_evt = 0; logic [7:0] core_status = 0, core_rdata = 0, tx_data = 0;
   logic [7:0] core_cmd, core_wdata, rx_data;
   logic       core_wr, tx_take, rx_put;
   logic [2:0] byte_idx;

   i2c_msg_seq u0 (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr),
      .tbl_flags(tbl_flags), .tbl_len(tbl_len), .go(go), .msg_count(msg_count),
      .tmo_cycles(tmo_cycles), .busy(busy), .done(done), .result(result),
      .core_evt(core_evt), .core_status(core_status), .core_rdata(core_rdata),
      .core_cmd(core_cmd), .core_wr(core_wr), .core_wdata(core_wdata),
      .tx_data(tx_data), .tx_take(tx_take), .rx_put(rx_put), .rx_data(rx_data),
      .byte_idx(byte_idx)
   );

   int checks = 0, fails = 0;
   logic [39:0] expq[$];
   string       tagq[$];
   logic [39:0] obs, ex;
   string       tg;

   function automatic logic [39:0] mk(input logic d, input logic [1:0] r, input logic [7:0] c,
                                      input logic w, input logic [7:0] wd, input logic t,
                                      input logic p, input logic [7:0] rd, input logic [2:0] ix);
      return {7'd0, d, r, c, w, wd, t, p, rd, ix};
   endfunction

   // monitor: every observable output event is compared against the queue
   always @(negedge clk) begin
      if (rst_n) begin
         obs = mk(done, done ? result : 2'd0, core_cmd, core_wr, core_wr ? core_wdata : 8'd0,
                  tx_take, rx_put, rx_put ? rx_data : 8'd0,
                  (tx_take || rx_put) ? byte_idx : 3'd0);
         if (obs != '0) begin
            checks++;
            if (expq.size() == 0) begin
               fails++;
               $display("FAIL unexpected output: actual %h expected nothing", obs);
            end else begin
               ex = expq.pop_front();
               tg = tagq.pop_front();
               if (ex !== obs) begin
                  fails++;
                  $display("FAIL %s: actual %h expected %h", tg, obs, ex);
               end
            end
         end
      end
   end

   task automatic expect_item(input logic [39:0] it, input string tag);
      expq.push_back(it);
      tagq.push_back(tag);
   endtask

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wd(input int sel, input logic [6:0] a, input logic [3:0] f, input logic [15:0] l);
      @(negedge clk);
      tbl_we = 1; tbl_sel = 3'(sel); tbl_addr = a; tbl_flags = f; tbl_len = l;
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic pulse_go(input int cnt);
      @(negedge clk);
      msg_count = 4'(cnt); go = 1;
      @(negedge clk);
      go = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic ev(input logic [7:0] st, input logic [7:0] rd, input logic [7:0] txd);
      @(negedge clk);
      core_status = st; core_rdata = rd; tx_data = txd; core_evt = 1;
      @(negedge clk);
      core_evt = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic drain(input string tag);
      repeat (4) @(negedge clk);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL %s: actual %0d items pending expected 0", tag, expq.size());
         expq.delete();
         tagq.delete();
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check_eq("R1 busy", busy, 0);
      check_eq("R1 done", done, 0);
      check_eq("R1 cmd", core_cmd, 0);

      // single two-byte write to 0x50
      wd(0, 7'h50, 4'h0, 16'd2);
      expect_item(mk(0,0,C_SS,0,0,0,0,0,0), "R4 start");
      pulse_go(1);
      check_eq("R4 busy", busy, 1);
      pulse_go(1);                           // R4: ignored while busy
      expect_item(mk(0,0,C_AE|C_SC|C_EC,1,8'hA0,0,0,0,0), "R5 address");
      ev(8'h08, 0, 0);
      ev(8'hF8, 0, 0);                       // R10: ignored status
      expect_item(mk(0,0,C_AE|C_EC,1,8'h5A,1,0,0,0), "R7 byte0");
      ev(8'h18, 0, 8'h5A);
      expect_item(mk(0,0,C_AE|C_EC,1,8'hC3,1,0,0,0), "R7 byte1");
      ev(8'h28, 0, 8'hC3);
      expect_item(mk(1,0,C_SP|C_EC,0,0,0,0,0,0), "R9 end ok");
      ev(8'h28, 0, 0);
      drain("R9 write list");
      check_eq("R12 busy after done", busy, 0);

      // fused write run with empty entry, then fused read run
      wd(0, 7'h22, 4'h0, 16'd1);
      wd(1, 7'h01, 4'h2, 16'd0);
      wd(2, 7'h02, 4'h2, 16'd2);
      wd(3, 7'h33, 4'h1, 16'd1);
      wd(4, 7'h04, 4'h3, 16'd1);
      expect_item(mk(0,0,C_SS,0,0,0,0,0,0), "R4 start");
      pulse_go(5);
      expect_item(mk(0,0,C_AE|C_SC|C_EC,1,8'h44,0,0,0,0), "R5 address");
      ev(8'h08, 0, 0);
      expect_item(mk(0,0,C_AE|C_EC,1,8'h01,1,0,0,3'd0), "R6 idx0");
      ev(8'h18, 0, 8'h01);
      expect_item(mk(0,0,C_AE|C_EC,1,8'h02,1,0,0,3'd2), "R6 skip empty");
      ev(8'h28, 0, 8'h02);
      expect_item(mk(0,0,C_AE|C_EC,1,8'h03,1,0,0,3'd2), "R6 idx2");
      ev(8'h28, 0, 8'h03);
      expect_item(mk(0,0,C_SS|C_EC,0,0,0,0,0,0), "R9 restart");
      ev(8'h28, 0, 0);
      expect_item(mk(0,0,C_AE|C_SC|C_EC,1,8'h67,0,0,0,0), "R5 read address");
      ev(8'h10, 0, 0);
      expect_item(mk(0,0,C_AE|C_EC,0,0,0,0,0,0), "R8 ack two left");
      ev(8'h40, 0, 0);
      expect_item(mk(0,0,C_AD|C_EC,0,0,0,1,8'h11,3'd3), "R8 push idx3");
      ev(8'h50, 8'h11, 0);
      expect_item(mk(1,0,C_SP|C_EC,0,0,0,1,8'h22,3'd4), "R6 push idx4");
      ev(8'h58, 8'h22, 0);
      drain("R6 fused list");

      // address NACK
      expect_item(mk(0,0,C_SS,0,0,0,0,0,0), "R4 start");
      pulse_go(1);
      expect_item(mk(0,0,C_AE|C_SC|C_EC,1,8'h44,0,0,0,0), "R5 address");
      ev(8'h08, 0, 0);
      expect_item(mk(1,1,C_SP|C_AE|C_EC,0,0,0,0,0,0), "R10 nack");
      ev(8'h20, 0, 0);
      drain("R10 nack");
      check_eq("R12 result held", result, 1);

      // data NACK with bytes left
      expect_item(mk(0,0,C_SS,0,0,0,0,0,0), "R4 start");
      pulse_go(1);
      expect_item(mk(0,0,C_AE|C_SC|C_EC,1,8'h44,0,0,0,0), "R5 address");
      ev(8'h08, 0, 0);
      expect_item(mk(1,1,C_SP|C_EC,0,0,0,0,0,0), "R7 data nack");
      ev(8'h30, 0, 0);
      drain("R7 data nack");

      // unlisted status
      expect_item(mk(0,0,C_SS,0,0,0,0,0,0), "R4 start");
      pulse_go(1);
      expect_item(mk(1,1,8'h00,0,0,0,0,0,0), "R10 unknown status");
      ev(8'h99, 0, 0);
      drain("R10 unknown");

      // write then no-start read: rejected mid transfer
      wd(0, 7'h22, 4'h0, 16'd0);
      wd(1, 7'h01, 4'h3, 16'd1);
      expect_item(mk(0,0,C_SS,0,0,0,0,0,0), "R4 start");
      pulse_go(2);
      expect_item(mk(0,0,C_AE|C_SC|C_EC,1,8'h44,0,0,0,0), "R5 address");
      ev(8'h08, 0, 0);
      expect_item(mk(1,2,C_SP|C_EC,0,0,0,0,0,0), "R9 nostart direction change");
      ev(8'h18, 0, 0);
      drain("R9 reject");

      // up-front validation
      wd(0, 7'h22, 4'h2, 16'd0);
      expect_item(mk(1,2,8'h00,0,0,0,0,0,0), "R3 head nostart");
      pulse_go(1);
      drain("R3 head");
      wd(0, 7'h22, 4'h0, 16'd0);
      wd(1, 7'h01, 4'h4, 16'd1);
      expect_item(mk(1,2,8'h00,0,0,0,0,0,0), "R3 unsupported flag");
      pulse_go(2);
      drain("R3 flag");
      expect_item(mk(0,0,C_SS,0,0,0,0,0,0), "R3 unchecked entry beyond count");
      pulse_go(1);
      expect_item(mk(0,0,C_AE|C_SC|C_EC,1,8'h44,0,0,0,0), "R5 address");
      ev(8'h08, 0, 0);
      expect_item(mk(1,0,C_SP|C_EC,0,0,0,0,0,0), "R9 empty write ok");
      ev(8'h18, 0, 0);
      drain("R3 boundary");

      // empty list
      expect_item(mk(1,0,8'h00,0,0,0,0,0,0), "R2 empty list");
      pulse_go(0);
      drain("R2");

      // timeout
      tmo_cycles = 24'd40;
      expect_item(mk(0,0,C_SS,0,0,0,0,0,0), "R4 start");
      expect_item(mk(0,0,C_OFF,0,0,0,0,0,0), "R11 core off");
      expect_item(mk(1,3,C_ON,0,0,0,0,0,0), "R11 core on");
      pulse_go(1);
      repeat (60) @(negedge clk);
      drain("R11 timeout");
      check_eq("R11 busy", busy, 0);
      check_eq("R12 result held", result, 3);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule